// File: doc/BRIEF.md
# Bit-Slice Corner-Turning Router

This block moves data bit by bit from sixteen 8-bit source registers into sixteen 16-bit destination registers. The source registers sit in two banks of eight. Each bank has its own 1-of-8 selector. The top bit of the source index picks which bank's selector is enabled, so exactly one source drives the single shared bus bit. A 4-bit destination address steers that bit through a distributor. The distributor's inhibit input is driven from the inverted bus bit, so only the addressed line can carry a one. The addressed destination register shifts the line in when a transfer fires.

The router can be driven by hand, using a source index, a destination index, a transfer pulse and a source-shift pulse. It also has a built-in corner-turn sequencer. Once started, the sequencer visits all sixteen sources for each bit significance, one source per cycle. It shifts every source register once after the sixteenth visit. As a result, all current MSBs land in destination 0, all next bits land in destination 1, and so on. After eight shifts the sequencer raises a one-cycle completion pulse.

Top module: `ctr_router`

## Requirements
- R1: After reset, every source and destination register reads zero, `busy` is 0 and `done` is 0.
- R2: While idle, a `load` pulse writes source s from `load_data[s*8 +: 8]`. Bit 7 of each slice is that source's MSB.
- R3: `bank_en` is one-hot: bit 0 when the active source index is below 8, bit 1 otherwise. `bus_bit` equals bit 7 of the active source register, and the disabled bank contributes nothing.
- R4: While idle, a `man_xfer` pulse shifts `bus_bit` into destination `man_dst` as its new bit 0, with the old bits moving up by one (`{q[14:0], bus_bit}`). Destination d appears on `dst_q[d*16 +: 16]`. Every other destination is unchanged, and no destination changes without a transfer.
- R5: While idle, a `man_shift` pulse without `load` shifts every source register left by one with a zero fill. If `load` is also high, the load wins.
- R6: A `start` pulse while idle raises `busy` at the next edge. `busy` stays high for exactly 128 cycles, and `done` is high for exactly the one cycle after `busy` falls.
- R7: A run visits the sources 0..15 in turn for each bit position. When it ends, bit (15-s) of destination d holds bit (7-d) of source s as loaded, and every source register reads zero.
- R8: While `busy`, the `load`, `man_shift`, `man_xfer`, `man_src` and `man_dst` inputs have no effect. Destinations 8..15 keep their values during a run.
- R9: A `start` pulse while `busy` is ignored: the run still ends after 128 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Parallel load of all source registers |
| load_data | input | 128 | Source load values, 8 bits per source |
| man_src | input | 4 | Manual source index |
| man_dst | input | 4 | Manual destination index |
| man_xfer | input | 1 | Manual transfer pulse |
| man_shift | input | 1 | Manual source shift pulse |
| start | input | 1 | Start a corner-turn run |
| bus_bit | output | 1 | Shared bus bit |
| bank_en | output | 2 | Selector enable per bank |
| dst_q | output | 256 | Destination registers, 16 bits each |
| busy | output | 1 | Sequencer running |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions check the following on every cycle:
- exactly one bank is enabled, and a disabled bank drives no bit;
- at most one distributor line is active;
- no destination changes without a transfer;
- sources stay frozen during a run except at the sequencer's shift;
- `done` follows the fall of `busy` for a single cycle.

Only the bench scenarios can show the bit-for-bit corner-turned pattern, the exact 128-cycle run length, shift-in order, and that manual inputs and restart attempts during a run leave the results untouched.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  // bank that holds a given source index
  function automatic int bank_of(input int idx, input int bank_sz);
    return idx / bank_sz;
  endfunction

  // position of a source inside its bank
  function automatic int lane_of(input int idx, input int bank_sz);
    return idx % bank_sz;
  endfunction

  // distributor line: addressed and not inhibited
  function automatic logic dist_line(input int line, input int addr, input logic inh);
    return (line == addr) && !inh;
  endfunction

  // shift a new bit into the low end of a register
  function automatic logic [15:0] shift_in16(input logic [15:0] q, input logic b);
    return {q[14:0], b};
  endfunction

endpackage

// File: rtl/src_bank.sv
module src_bank #(
  parameter int BANK_SZ = 8,
  parameter int W       = 8,
  localparam int LANE_W = (BANK_SZ > 1) ? $clog2(BANK_SZ) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [BANK_SZ*W-1:0]   load_data,
  input  logic                   shift,
  input  logic [LANE_W-1:0]      lane,
  input  logic                   en,
  output logic                   bit_o,
  output logic [BANK_SZ*W-1:0]   q_flat
);

  logic [W-1:0] regs [BANK_SZ];

  for (genvar i = 0; i < BANK_SZ; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs[i] <= '0;
      else if (load)  regs[i] <= load_data[i*W +: W];
      else if (shift) regs[i] <= {regs[i][W-2:0], 1'b0};
    end
    assign q_flat[i*W +: W] = regs[i];
  end

  // a disabled selector drives zero onto the shared bus
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < BANK_SZ; i++)
      if (en && (int'(lane) == i)) bit_o = regs[i][W-1];
  end

endmodule

// File: rtl/bit_distributor.sv
module bit_distributor #(
  parameter int N_DST   = 16,
  localparam int DST_AW = $clog2(N_DST)
) (
  input  logic [DST_AW-1:0] addr,
  input  logic              inh,
  output logic [N_DST-1:0]  lines
);
  import ctr_pkg::*;

  for (genvar d = 0; d < N_DST; d++) begin : g_line
    assign lines[d] = dist_line(d, int'(addr), inh);
  end

endmodule

// File: rtl/dst_regs.sv
module dst_regs #(
  parameter int N_DST   = 16,
  parameter int DW      = 16,
  localparam int DST_AW = $clog2(N_DST)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic [DST_AW-1:0]   addr,
  input  logic [N_DST-1:0]    lines,
  output logic [N_DST*DW-1:0] q_flat
);

  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (strobe && (int'(addr) == d))
        q <= {q[DW-2:0], lines[d]};
    end
    assign q_flat[d*DW +: DW] = q;
  end

endmodule

// File: rtl/corner_seq.sv
module corner_seq #(
  parameter int N_SRC   = 16,
  parameter int W       = 8,
  parameter int N_DST   = 16,
  localparam int SRC_AW = $clog2(N_SRC),
  localparam int BIT_AW = $clog2(W),
  localparam int DST_AW = $clog2(N_DST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [SRC_AW-1:0] seq_src,
  output logic [DST_AW-1:0] seq_dst,
  output logic              seq_shift
);

  logic [SRC_AW-1:0] step;
  logic [BIT_AW-1:0] bit_pos;
  logic              last_step, last_bit;

  assign last_step = (step == SRC_AW'(N_SRC - 1));
  assign last_bit  = (bit_pos == BIT_AW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      step    <= '0;
      bit_pos <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        step    <= '0;
        bit_pos <= '0;
        if (start) busy <= 1'b1;
      end else if (last_step) begin
        step <= '0;
        if (last_bit) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bit_pos <= bit_pos + 1'b1;
        end
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  assign seq_src   = step;
  assign seq_dst   = DST_AW'(bit_pos);
  assign seq_shift = busy && last_step;

endmodule

// File: rtl/ctr_router.sv
module ctr_router #(
  parameter int N_SRC   = 16,
  parameter int BANK_SZ = 8,
  parameter int W       = 8,
  parameter int N_DST   = 16,
  localparam int N_BANK = N_SRC / BANK_SZ,
  localparam int SRC_AW = $clog2(N_SRC),
  localparam int DST_AW = $clog2(N_DST),
  localparam int LANE_W = (BANK_SZ > 1) ? $clog2(BANK_SZ) : 1,
  localparam int DW     = N_SRC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [N_SRC*W-1:0]   load_data,
  input  logic [SRC_AW-1:0]    man_src,
  input  logic [DST_AW-1:0]    man_dst,
  input  logic                 man_xfer,
  input  logic                 man_shift,
  input  logic                 start,
  output logic                 bus_bit,
  output logic [N_BANK-1:0]    bank_en,
  output logic [N_DST*DW-1:0]  dst_q,
  output logic                 busy,
  output logic                 done
);
  import ctr_pkg::*;

  logic [SRC_AW-1:0]   seq_src, src_idx;
  logic [DST_AW-1:0]   seq_dst, dst_idx;
  logic                seq_shift, src_shift, src_load, xfer_fire;
  logic [LANE_W-1:0]   lane;
  logic [N_BANK-1:0]   bank_bits;
  logic [N_DST-1:0]    dec_line;
  logic [N_SRC*W-1:0]  src_flat;

  corner_seq #(.N_SRC(N_SRC), .W(W), .N_DST(N_DST)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .seq_src(seq_src), .seq_dst(seq_dst), .seq_shift(seq_shift)
  );

  // manual controls only act while the sequencer is idle
  assign src_idx   = busy ? seq_src : man_src;
  assign dst_idx   = busy ? seq_dst : man_dst;
  assign xfer_fire = busy | man_xfer;
  assign src_load  = load & ~busy;
  assign src_shift = busy ? seq_shift : (man_shift & ~load);
  assign lane      = LANE_W'(lane_of(int'(src_idx), BANK_SZ));

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    assign bank_en[b] = (bank_of(int'(src_idx), BANK_SZ) == b);
    src_bank #(.BANK_SZ(BANK_SZ), .W(W)) u_bank (
      .clk(clk), .rst_n(rst_n), .load(src_load),
      .load_data(load_data[b*BANK_SZ*W +: BANK_SZ*W]),
      .shift(src_shift), .lane(lane), .en(bank_en[b]),
      .bit_o(bank_bits[b]), .q_flat(src_flat[b*BANK_SZ*W +: BANK_SZ*W])
    );
  end

  assign bus_bit = |bank_bits;

  // bus bit feeds the inhibit path: a zero on the bus inhibits every line
  bit_distributor #(.N_DST(N_DST)) u_dist (
    .addr(dst_idx), .inh(~bus_bit), .lines(dec_line)
  );

  dst_regs #(.N_DST(N_DST), .DW(DW)) u_dst (
    .clk(clk), .rst_n(rst_n), .strobe(xfer_fire), .addr(dst_idx),
    .lines(dec_line), .q_flat(dst_q)
  );

endmodule

// File: rtl/ctr_router_chk.sv
module ctr_router_chk #(
  parameter int N_BANK = 2,
  parameter int N_DST  = 16,
  parameter int SW     = 128,
  parameter int QW     = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [N_BANK-1:0] bank_en,
  input logic [N_BANK-1:0] bank_bits,
  input logic [N_DST-1:0]  dec_line,
  input logic              xfer_fire,
  input logic              seq_shift,
  input logic [SW-1:0]     src_flat,
  input logic [QW-1:0]     dst_q
);

  p_bank_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(bank_en));

  p_idle_bank_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_bits & ~bank_en) == '0);

  p_single_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_line));

  p_no_xfer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_fire |=> $stable(dst_q));

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_src_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_shift) |=> $stable(src_flat));

endmodule

bind ctr_router ctr_router_chk #(
  .N_BANK(N_BANK), .N_DST(N_DST), .SW(N_SRC*W), .QW(N_DST*DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .bank_en(bank_en), .bank_bits(bank_bits), .dec_line(dec_line),
  .xfer_fire(xfer_fire), .seq_shift(seq_shift), .src_flat(src_flat),
  .dst_q(dst_q)
);

// File: tb/ctr_router_bench.sv
module ctr_router_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [127:0] load_data = '0;
  logic [3:0]   man_src = '0;
  logic [3:0]   man_dst = '0;
  logic         man_xfer = 1'b0;
  logic         man_shift = 1'b0;
  logic         start = 1'b0;
  logic         bus_bit;
  logic [1:0]   bank_en;
  logic [255:0] dst_q;
  logic         busy, done;

  ctr_router u_ctr_router (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
    .man_src(man_src), .man_dst(man_dst), .man_xfer(man_xfer),
    .man_shift(man_shift), .start(start), .bus_bit(bus_bit),
    .bank_en(bank_en), .dst_q(dst_q), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string       req;
    int          sel;   // >=0 destination, -1 bus, -2 busy, -3 done, -4 bank_en
    logic [15:0] exp;
  } sb_item_t;

  sb_item_t    sb[$];
  int          total = 0, bad = 0;
  logic [7:0]  m_src [16];
  logic [15:0] m_dst [16];

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // monitor: compare queued expectations at each falling edge
  initial forever begin
    @(negedge clk);
    while (sb.size() > 0) begin
      sb_item_t it;
      logic [15:0] got;
      it = sb.pop_front();
      case (it.sel)
        -1:      got = {15'd0, bus_bit};
        -2:      got = {15'd0, busy};
        -3:      got = {15'd0, done};
        -4:      got = {14'd0, bank_en};
        default: got = dst_q[it.sel*16 +: 16];
      endcase
      check(it.req, got, it.exp);
    end
  end

  task automatic push(input string req, input int sel, input logic [15:0] exp);
    sb.push_back('{req: req, sel: sel, exp: exp});
  endtask

  task automatic push_dsts(input string req);
    for (int d = 0; d < 16; d++) push(req, d, m_dst[d]);
  endtask

  task automatic step_drive();
    @(negedge clk); #1;
  endtask

  task automatic do_load(input logic [127:0] v);
    step_drive();
    load_data = v; load = 1'b1;
    @(posedge clk); #1 load = 1'b0;
    for (int s = 0; s < 16; s++) m_src[s] = v[s*8 +: 8];
  endtask

  task automatic peek_src(input int s, input string req);
    step_drive();
    man_src = 4'(s);
    push(req, -1, {15'd0, m_src[s][7]});
    push("R3 bank", -4, (s < 8) ? 16'd1 : 16'd2);
    @(negedge clk);
  endtask

  task automatic man_move(input int s, input int d, input logic fire);
    step_drive();
    man_src = 4'(s); man_dst = 4'(d); man_xfer = fire;
    @(posedge clk); #1 man_xfer = 1'b0;
    if (fire) m_dst[d] = {m_dst[d][14:0], m_src[s][7]};
    push_dsts(fire ? "R4 xfer" : "R4 no-strobe");
    @(negedge clk);
  endtask

  task automatic run_corner(input logic [127:0] v);
    int cyc;
    do_load(v);
    step_drive();
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    // expected: bits of significance 7-b from sources 0..15 into dst b
    for (int b = 0; b < 8; b++) begin
      for (int s = 0; s < 16; s++) m_dst[b] = {m_dst[b][14:0], m_src[s][7]};
      for (int s = 0; s < 16; s++) m_src[s] = {m_src[s][6:0], 1'b0};
    end
    // disturb manual inputs mid-run (R8) and retry start (R9)
    cyc = 0;
    while (busy && cyc < 1000) begin
      @(negedge clk); #1;
      cyc++;
      man_xfer = 1'b1; man_dst = 4'd12; man_src = 4'd9;
      man_shift = cyc[0]; load = (cyc == 40); load_data = ~v;
      start = (cyc == 60);
      @(posedge clk); #1;
      man_xfer = 1'b0; man_shift = 1'b0; load = 1'b0; start = 1'b0;
    end
    check("R6 run length", 16'(cyc), 16'd128);
    @(negedge clk);
    check("R6 done pulse", {15'd0, done}, 16'd1);
    @(negedge clk);
    check("R6 done clears", {15'd0, done}, 16'd0);
    check("R9 no restart", {15'd0, busy}, 16'd0);
    push_dsts("R7 corner/R8 hold");
    @(negedge clk);
    for (int s = 0; s < 16; s += 5) peek_src(s, "R7 drained");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_src[i] = '0; m_dst[i] = '0; end
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    @(negedge clk);
    push_dsts("R1 reset");
    push("R1 busy", -2, 16'd0);
    push("R1 done", -3, 16'd0);
    @(negedge clk);
    peek_src(3, "R1 src zero");

    do_load(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    for (int s = 0; s < 16; s += 3) peek_src(s, "R2 load/R3 bus");
    peek_src(15, "R3 upper bank");

    step_drive();
    man_shift = 1'b1;
    @(posedge clk); #1 man_shift = 1'b0;
    for (int s = 0; s < 16; s++) m_src[s] = {m_src[s][6:0], 1'b0};
    peek_src(1, "R5 shift");
    peek_src(10, "R5 shift");

    // load wins over simultaneous shift
    step_drive();
    man_shift = 1'b1;
    do_load(128'h8000_0000_0000_0000_0000_0000_0000_0080);
    man_shift = 1'b0;
    peek_src(0, "R5 load wins");
    peek_src(15, "R5 load wins");

    man_move(0, 9, 1'b1);
    man_move(15, 9, 1'b1);
    man_move(1, 9, 1'b1);
    man_move(0, 14, 1'b1);
    man_move(0, 3, 1'b0);

    run_corner(128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F);
    run_corner(128'hA5A5_0000_FFFF_1234_8001_7FFE_C3C3_0F0F);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule